// File: doc/BRIEF.md
# Transceiver Loop Delay Meter

This block measures how long a transmitted edge takes to come back through the bus transceiver. A one-cycle start pulse marks a recessive-to-dominant transition driven onto the transmit line. A one-cycle stop pulse marks the matching valid recessive-to-dominant transition seen on the receive line. The block counts system clock edges between the two pulses. The count is the loop delay in clock cycles, and it saturates at the largest value the counter can hold.

When a measurement completes, the block also works out a secondary sample point position. It takes the new delay and the offset supplied by software, combines them according to a two-bit source code, and optionally clips the result at a fixed limit. The delay and the sample point position are held in shadow registers. Software therefore always reads the result of the last finished measurement, and the values never change while a count is running. Edge detection, bit timing and register access all sit outside this block.

Top module: `loop_delay_meter`

## Requirements
- R1: A synchronous active-high reset clears the busy flag, the delay result and the sample point result to zero.
- R2: A start pulse sampled while the enable input is high sets the busy flag from the next cycle on. The flag stays high until a measurement completes.
- R3: A stop pulse sampled while busy ends the measurement. The delay result then equals the number of rising clock edges from the start edge to the stop edge (stop one edge after start gives 1). Both results update right after the stop edge.
- R4: The delay saturates at 2^W-1 (W is the counter width). A stop after a longer wait reports that maximum.
- R5: A start pulse sampled while the enable input is low is ignored: busy stays low and the results do not change.
- R6: A start pulse sampled while busy restarts the count from zero. When start and stop are sampled on the same edge, the restart wins and the results are not updated.
- R7: A stop pulse sampled while not busy is ignored: the results and the busy flag are unchanged.
- R8: The source code sets the sample point value. Code 0 and code 3 give the delay. Code 1 gives the delay plus the offset, computed one bit wider than the delay so that it never wraps. Code 2 gives the offset alone.
- R9: With saturation enabled, the sample point result never exceeds the configured limit. A larger value is replaced by the limit.
- R10: Both results change only when a measurement completes. Changes to the offset or the source code at any other time have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_start | input | 1 | Pulse on a transmitted recessive-to-dominant edge |
| meas_stop | input | 1 | Pulse on a valid received recessive-to-dominant edge |
| meas_en | input | 1 | Allows a start pulse to begin a measurement |
| ssp_offset | input | W | Software offset for the sample point |
| ssp_src | input | 2 | Sample point source code |
| meas_busy | output | 1 | High while a measurement runs |
| delay_q | output | W | Shadowed loop delay in clock cycles |
| ssp_q | output | W+1 | Shadowed secondary sample point position |

## Verification
Busy rises in the cycle after the edge that samples the start pulse, and falls in the cycle after the edge that samples the stop pulse. Both shadowed results are due in that same cycle, one register stage after the stop edge. The bench drives every pulse on the falling clock edge, so each pulse is sampled by exactly one rising edge. It reads the outputs on the next falling edge after the edge it is checking. It sweeps every delay up to past counter saturation, every offset and every source code on a narrow counter, and compares each result against an arithmetic model.

// File: rtl/loopdly_pkg.sv
package loopdly_pkg;

    typedef enum logic [1:0] {
        SSP_FROM_MEAS     = 2'd0,
        SSP_MEAS_PLUS_OFS = 2'd1,
        SSP_FROM_OFS      = 2'd2,
        SSP_ALIAS_MEAS    = 2'd3
    } ssp_src_e;

    typedef struct packed {
        logic restart;
        logic finish;
    } meas_evt_t;

    function automatic logic [31:0] clip_to(input logic [31:0] v, input logic [31:0] lim);
        return (v > lim) ? lim : v;
    endfunction

endpackage

// File: rtl/loopdly_counter.sv
module loopdly_counter
    import loopdly_pkg::*;
#(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         stop,
    input  logic         enable,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt;
    logic         run;
    meas_evt_t    evt;

    always_comb begin
        evt.restart = start & enable;
        evt.finish  = run & stop & ~evt.restart;
    end

    // Edges counted so far, including the current one, saturated.
    assign result = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
    assign done   = evt.finish;
    assign busy   = run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (evt.restart) begin
            cnt <= '0;
            run <= 1'b1;
        end else if (evt.finish) begin
            run <= 1'b0;
        end else if (run && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/loopdly_ssp_calc.sv
module loopdly_ssp_calc
    import loopdly_pkg::*;
#(
    parameter int W       = 7,
    parameter bit SAT_EN  = 1'b1,
    parameter int SAT_LVL = 200
) (
    input  logic [W-1:0] delay,
    input  logic [W-1:0] offset,
    input  logic [1:0]   src,
    output logic [W:0]   ssp
);
    localparam int OW = W + 1;

    logic [OW-1:0] sum;
    logic [OW-1:0] raw;
    ssp_src_e      sel;

    assign sel = ssp_src_e'(src);
    assign sum = {1'b0, delay} + {1'b0, offset};

    always_comb begin
        unique case (sel)
            SSP_MEAS_PLUS_OFS: raw = sum;
            SSP_FROM_OFS:      raw = {1'b0, offset};
            default:           raw = {1'b0, delay};
        endcase
    end

    generate
        if (SAT_EN) begin : g_sat
            logic [31:0] clipped;
            assign clipped = clip_to(32'(raw), 32'(SAT_LVL));
            assign ssp     = clipped[OW-1:0];
        end else begin : g_nosat
            assign ssp = raw;
        end
    endgenerate
endmodule

// File: rtl/loopdly_shadow.sv
module loopdly_shadow #(
    parameter int WD = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [WD-1:0] d,
    output logic [WD-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/loop_delay_meter.sv
module loop_delay_meter
    import loopdly_pkg::*;
#(
    parameter int W       = 7,
    parameter bit SAT_EN  = 1'b1,
    parameter int SAT_LVL = 200
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         meas_start,
    input  logic         meas_stop,
    input  logic         meas_en,
    input  logic [W-1:0] ssp_offset,
    input  logic [1:0]   ssp_src,
    output logic         meas_busy,
    output logic [W-1:0] delay_q,
    output logic [W:0]   ssp_q
);
    logic         done;
    logic [W-1:0] fresh_delay;
    logic [W:0]   fresh_ssp;

    loopdly_counter #(.W(W)) i_counter (
        .clk    (clk),
        .rst    (rst),
        .start  (meas_start),
        .stop   (meas_stop),
        .enable (meas_en),
        .busy   (meas_busy),
        .done   (done),
        .result (fresh_delay)
    );

    loopdly_ssp_calc #(.W(W), .SAT_EN(SAT_EN), .SAT_LVL(SAT_LVL)) i_ssp (
        .delay  (fresh_delay),
        .offset (ssp_offset),
        .src    (ssp_src),
        .ssp    (fresh_ssp)
    );

    loopdly_shadow #(.WD(W)) i_sh_delay (
        .clk (clk), .rst (rst), .load (done), .d (fresh_delay), .q (delay_q)
    );

    loopdly_shadow #(.WD(W + 1)) i_sh_ssp (
        .clk (clk), .rst (rst), .load (done), .d (fresh_ssp), .q (ssp_q)
    );
endmodule

// File: rtl/loop_delay_meter_chk.sv
module loop_delay_meter_chk #(
    parameter int W       = 7,
    parameter bit SAT_EN  = 1'b1,
    parameter int SAT_LVL = 200
) (
    input logic         clk,
    input logic         rst,
    input logic         meas_start,
    input logic         meas_stop,
    input logic         meas_en,
    input logic         meas_busy,
    input logic [W-1:0] delay_q,
    input logic [W:0]   ssp_q
);
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (!meas_busy && delay_q == '0 && ssp_q == '0));

    p_busy_set_r2: assert property (@(posedge clk) disable iff (rst)
        (meas_start && meas_en) |=> meas_busy);

    p_busy_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (meas_busy && meas_stop && !(meas_start && meas_en)) |=> !meas_busy);

    p_start_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (!meas_busy && meas_start && !meas_en) |=> (!meas_busy && $stable(delay_q)));

    p_idle_stop_r7: assert property (@(posedge clk) disable iff (rst)
        (!meas_busy && meas_stop && !(meas_start && meas_en)) |=> ($stable(delay_q) && $stable(ssp_q)));

    p_shadow_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(meas_busy && meas_stop && !(meas_start && meas_en)) |=> ($stable(delay_q) && $stable(ssp_q)));

    p_ssp_limit_r9: assert property (@(posedge clk) disable iff (rst)
        SAT_EN |-> (32'(ssp_q) <= 32'(SAT_LVL)));
endmodule

bind loop_delay_meter loop_delay_meter_chk #(.W(W), .SAT_EN(SAT_EN), .SAT_LVL(SAT_LVL)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .meas_start (meas_start),
    .meas_stop  (meas_stop),
    .meas_en    (meas_en),
    .meas_busy  (meas_busy),
    .delay_q    (delay_q),
    .ssp_q      (ssp_q)
);

// File: tb/test_loop_delay_meter.sv
module test_loop_delay_meter;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 4;
    localparam int SAT_LVL    = 20;
    localparam int MAXD       = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         meas_start = 1'b0;
    logic         meas_stop = 1'b0;
    logic         meas_en = 1'b1;
    logic [W-1:0] ssp_offset = '0;
    logic [1:0]   ssp_src = 2'd0;
    logic         meas_busy;
    logic [W-1:0] delay_q;
    logic [W:0]   ssp_q;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_d    = 0;
    int exp_s    = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    loop_delay_meter #(.W(W), .SAT_EN(1'b1), .SAT_LVL(SAT_LVL)) i_loop_delay_meter (
        .clk        (clk),
        .rst        (rst),
        .meas_start (meas_start),
        .meas_stop  (meas_stop),
        .meas_en    (meas_en),
        .ssp_offset (ssp_offset),
        .ssp_src    (ssp_src),
        .meas_busy  (meas_busy),
        .delay_q    (delay_q),
        .ssp_q      (ssp_q)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model_ssp(input int d, input int ofs, input int src);
        int raw;
        raw = (src == 1) ? d + ofs : (src == 2) ? ofs : d;
        return (raw > SAT_LVL) ? SAT_LVL : raw;
    endfunction

    // Start sampled on edge k, stop on edge k+d; returns after edge k+d (at a falling edge).
    task automatic measure(input int d);
        meas_start = 1'b1;
        @(negedge clk);
        meas_start = 1'b0;
        for (int j = 1; j < d; j++) begin
            @(negedge clk);
            if (j == 1) check("R2 busy", int'(meas_busy), 1);
        end
        meas_stop = 1'b1;
        @(negedge clk);
        meas_stop = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy", int'(meas_busy), 0);
        check("R1 delay", int'(delay_q), 0);
        check("R1 ssp", int'(ssp_q), 0);
        rst = 1'b0;
        @(negedge clk);

        // R3 R4 R8 R9: sweep of delay, offset and source code
        for (int d = 1; d <= MAXD + 3; d++) begin
            for (int ofs = 0; ofs <= MAXD; ofs++) begin
                for (int src = 0; src < 4; src++) begin
                    ssp_offset = W'(ofs);
                    ssp_src    = 2'(src);
                    measure(d);
                    exp_d = (d > MAXD) ? MAXD : d;
                    check("R3 R4 delay", int'(delay_q), exp_d);
                    check("R8 R9 ssp", int'(ssp_q), model_ssp(exp_d, ofs, src));
                    check("R3 busy low", int'(meas_busy), 0);
                end
            end
        end

        // R10: offset/source changes after completion do not alter outputs
        ssp_offset = 4'd3; ssp_src = 2'd1;
        measure(5);
        exp_d = 5; exp_s = 8;
        ssp_offset = 4'd9; ssp_src = 2'd2;
        repeat (3) @(negedge clk);
        check("R10 delay held", int'(delay_q), exp_d);
        check("R10 ssp held", int'(ssp_q), exp_s);
        // R10: results hold while a new measurement runs
        meas_start = 1'b1;
        @(negedge clk);
        meas_start = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 hold while busy", int'(delay_q), exp_d);
        check("R10 ssp hold while busy", int'(ssp_q), exp_s);
        meas_stop = 1'b1;
        @(negedge clk);
        meas_stop = 1'b0;
        check("R3 after hold", int'(delay_q), 4);
        check("R8 code 2 after hold", int'(ssp_q), 9);

        // R5: start with enable low ignored, then stop has no effect
        meas_en = 1'b0;
        meas_start = 1'b1;
        @(negedge clk);
        meas_start = 1'b0;
        check("R5 busy", int'(meas_busy), 0);
        repeat (2) @(negedge clk);
        meas_stop = 1'b1;
        @(negedge clk);
        meas_stop = 1'b0;
        check("R5 delay", int'(delay_q), 4);
        meas_en = 1'b1;

        // R7: stop while idle ignored
        meas_stop = 1'b1;
        @(negedge clk);
        meas_stop = 1'b0;
        check("R7 delay", int'(delay_q), 4);
        check("R7 ssp", int'(ssp_q), 9);
        check("R7 busy", int'(meas_busy), 0);

        // R6: restart mid-measurement
        ssp_src = 2'd0;
        meas_start = 1'b1;
        @(negedge clk);
        meas_start = 1'b0;
        repeat (2) @(negedge clk);
        measure(6);
        check("R6 restart delay", int'(delay_q), 6);

        // R6: start and stop together while busy -> restart, no update
        meas_start = 1'b1;
        @(negedge clk);
        meas_start = 1'b0;
        @(negedge clk);
        meas_start = 1'b1; meas_stop = 1'b1;
        @(negedge clk);
        meas_start = 1'b0; meas_stop = 1'b0;
        check("R6 same edge no update", int'(delay_q), 6);
        check("R6 same edge busy", int'(meas_busy), 1);
        measure(2);
        check("R6 after restart", int'(delay_q), 2);

        // R1: reset during a measurement
        meas_start = 1'b1;
        @(negedge clk);
        meas_start = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid busy", int'(meas_busy), 0);
        check("R1 mid delay", int'(delay_q), 0);
        check("R1 mid ssp", int'(ssp_q), 0);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule